// File: doc/BRIEF.md
# Overlapping 1011 Serial Sequence Detector

This block watches a one-bit serial stream, taking one bit on each rising clock edge when a bit-valid qualifier is high. It raises a detection pulse whenever the four most recently accepted bits, oldest first, read 1, 0, 1, 1. A match may share bits with the previous one, so the final 1 of a match can open the next match.

The design is a four-state machine with binary state codes. A control module decides the next state and the detection output. A state-register module holds the current state. The control passes a small command struct to the register. A debug port shows the current state code, so a test can follow the machine's path one step at a time.

Top module: `seq1011_detect`

## Requirements
- R1: A synchronous active-high reset puts the machine in the no-match state (debug code 0), and any partial match seen before the reset is discarded.
- R2: The debug port shows the state as a 2-bit code: 0 means nothing has matched, 1 means the last accepted bit was 1, 2 means the last two were 1 then 0, and 3 means the last three were 1, 0, 1.
- R3: From code 0, an accepted 1 moves to code 1 and an accepted 0 stays at 0. From code 1, an accepted 1 stays at 1 and an accepted 0 moves to code 2.
- R4: From code 2, an accepted 1 moves to code 3 and an accepted 0 returns to code 0.
- R5: From code 3, an accepted 1 raises the detection output and moves to code 1, not code 0, so overlapping matches are found.
- R6: From code 3, an accepted 0 moves to code 2 with no detection.
- R7: The detection output is combinational. It is high in the same cycle that the completing bit is presented with bit-valid high, and it lasts exactly one clock cycle for each match.
- R8: While bit-valid is low, the state does not change and the detection output stays low, whatever the value on the bit input.
- R9: The stream 0 1 0 1 1 0 1 1 0 1 1, with every bit valid, gives detections on the 5th, 8th and 11th bits only.
- R10: The stream 1 0 1 0 gives no detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; bits are taken on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bitIn | input | 1 | Serial data bit |
| bitValid | input | 1 | High when bitIn carries a bit to accept |
| matchPulse | output | 1 | One-cycle detection pulse |
| dbgState | output | 2 | Current state code |

## Verification
The hardest state to reach is code 3 when the next accepted bit is 0 or 1 and idle cycles fall in between. The stimulus has to build a 1, 0, 1 prefix and then either complete it or break it, with bit-valid dropped partway through. Directed streams set up these cases: overlapping runs such as 1011011, a 101 prefix broken by a 0, a prefix cut off by a reset, and valid gaps inside a prefix. A long pseudo-random stream with about a quarter of its cycles invalid then runs every transition many times. A history-based model in the bench checks both outputs on every cycle.

// File: rtl/seq1011_pkg.sv
package seq1011_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_10   = 2'd2,
    ST_101  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic      advance;
    seqState_t nextState;
  } stateCmd_t;

endpackage

// File: rtl/seq1011_state_reg.sv
module seq1011_state_reg
  import seq1011_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  stateCmd_t cmd,
  output seqState_t curState
);

  always_ff @(posedge clk) begin
    if (rst)
      curState <= ST_IDLE;
    else if (cmd.advance)
      curState <= cmd.nextState;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> curState == ST_IDLE)
    else $error("state not idle after reset");

endmodule

// File: rtl/seq1011_ctrl.sv
module seq1011_ctrl
  import seq1011_pkg::*;
(
  input  seqState_t curState,
  input  logic      bitIn,
  input  logic      bitValid,
  output stateCmd_t cmd,
  output logic      detect
);

  // next-state process
  always_comb begin
    cmd.advance   = bitValid;
    cmd.nextState = curState;
    case (curState)
      ST_IDLE: cmd.nextState = bitIn ? ST_ONE : ST_IDLE;
      ST_ONE:  cmd.nextState = bitIn ? ST_ONE : ST_10;
      ST_10:   cmd.nextState = bitIn ? ST_101 : ST_IDLE;
      ST_101:  cmd.nextState = bitIn ? ST_ONE : ST_10;
      default: cmd.nextState = ST_IDLE;
    endcase
  end

  // output process
  always_comb begin
    detect = 1'b0;
    if (bitValid && bitIn && (curState == ST_101))
      detect = 1'b1;
  end

endmodule

// File: rtl/seq1011_detect.sv
module seq1011_detect
  import seq1011_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bitIn,
  input  logic               bitValid,
  output logic               matchPulse,
  output logic [STATE_W-1:0] dbgState
);

  seqState_t curState;
  stateCmd_t cmd;

  seq1011_ctrl u_ctrl (
    .curState (curState),
    .bitIn    (bitIn),
    .bitValid (bitValid),
    .cmd      (cmd),
    .detect   (matchPulse)
  );

  seq1011_state_reg u_stateReg (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .curState (curState)
  );

  assign dbgState = curState;

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> $stable(dbgState))
    else $error("state moved without a valid bit");

  // R8
  no_detect_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    matchPulse |-> bitValid)
    else $error("detection without a valid bit");

  // R5
  overlap_resume_chk: assert property (@(posedge clk) disable iff (rst)
    matchPulse |=> dbgState == ST_ONE)
    else $error("match did not resume at one-bit prefix");

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    matchPulse |=> !matchPulse)
    else $error("detection wider than one cycle");

  // R6
  break_to_10_chk: assert property (@(posedge clk) disable iff (rst)
    (bitValid && !bitIn && dbgState == ST_101) |=> dbgState == ST_10)
    else $error("0 after 101 did not fall back to 10");

  // R4
  ten_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (bitValid && !bitIn && dbgState == ST_10) |=> dbgState == ST_IDLE)
    else $error("0 after 10 did not return to idle");

endmodule

// File: tb/seq1011_detect_bench.sv
module seq1011_detect_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitIn = 1'b0;
  logic       bitValid = 1'b0;
  logic       matchPulse;
  logic [1:0] dbgState;

  int compared = 0;
  int mismatched = 0;
  bit hist[$];

  always #5 clk = ~clk;

  seq1011_detect u_seq1011_detect (
    .clk        (clk),
    .rst        (rst),
    .bitIn      (bitIn),
    .bitValid   (bitValid),
    .matchPulse (matchPulse),
    .dbgState   (dbgState)
  );

  // longest suffix of the accepted history that is a proper prefix of 1011
  function automatic int modelState();
    bit pat [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    for (int len = 3; len >= 1; len--) begin
      if (hist.size() >= len) begin
        bit ok = 1'b1;
        for (int k = 0; k < len; k++)
          if (hist[hist.size() - len + k] != pat[k]) ok = 1'b0;
        if (ok) return len;
      end
    end
    return 0;
  endfunction

  task automatic check(string req, int actual, int expected, string what);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, actual, expected, $time);
    end
  endtask

  // present one bit, compare both outputs before the edge, then update the model
  task automatic step(bit b, bit v, string req);
    int expS;
    int expD;
    @(negedge clk);
    bitIn = b;
    bitValid = v;
    #2;
    expS = modelState();
    expD = (v && b && expS == 3) ? 1 : 0;
    check(req, int'(dbgState), expS, "state");
    check(req, int'(matchPulse), expD, "match");
    @(posedge clk);
    if (v) begin
      hist.push_back(b);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    bitValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    hist.delete();
    #1;
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(dbgState), 0, "reset state");
    check("R1", int'(matchPulse), 0, "reset match");
  endtask

  task automatic feed(bit bits[], string req);
    foreach (bits[i]) step(bits[i], 1'b1, req);
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit ex[11] = '{0,1,0,1,1,0,1,1,0,1,1};
    bit exp9[11] = '{0,0,0,0,1,0,0,1,0,0,1};
    int lfsr = 32'h1ACE5EED;
    doReset();

    // R9: worked example with explicit pulse positions
    foreach (ex[i]) begin
      @(negedge clk);
      bitIn = ex[i];
      bitValid = 1'b1;
      #2;
      check("R9", int'(matchPulse), int'(exp9[i]), "example pulse");
      @(posedge clk);
    end
    doReset();

    // R10: 1010 never matches
    feed('{1,0,1,0}, "R10");
    // R3: idle and one-prefix transitions
    feed('{0,0,1,1,1,0}, "R3");
    // R4: from 10, 0 back to idle, then 1 to 101
    feed('{0,1,0,1}, "R4");
    // R5: overlapping matches 1011011
    doReset();
    feed('{1,0,1,1,0,1,1}, "R5");
    // R6: 0 after 101 goes to 10, then completes
    feed('{1,0,1,0,1,1}, "R6");
    // R8: gaps with garbage bits inside a prefix and before the completing bit
    doReset();
    step(1, 1, "R8"); step(1, 0, "R8"); step(0, 1, "R8"); step(0, 0, "R8");
    step(1, 1, "R8"); step(1, 0, "R8"); step(0, 0, "R8"); step(1, 1, "R8");
    step(1, 0, "R7"); step(1, 1, "R7");
    // R1: reset discards a partial 101
    feed('{1,0,1}, "R1");
    doReset();
    step(1, 1, "R1");
    // R2 / R7: long pseudo-random stream
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[3], lfsr[7] | lfsr[11], "R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule